// File: doc/BRIEF.md
# Weighted-Average Singleton Defuzzifier

This block produces the crisp output of a zero-order fuzzy inference stage whose rule consequents are constants. Fifteen rules cover every pairing of five traffic-load terms with three load-change terms. Each rule carries an 8-bit firing strength from an upstream rule evaluator. A fixed rule map assigns each rule one of three 8-bit output constants: low, normal or high.

The block forms the sum of strength times constant and the sum of strengths, then divides the first by the second. The quotient is scaled by 256, so the 16-bit result keeps a fractional byte. A downstream comparator uses the result to choose one of three supply operating points.

A one-cycle `start` pulse launches a computation. A one-cycle `valid` pulse marks the result three clock edges later. The pipeline accepts a new computation on every cycle.

Top module: `wavg_defuzz`

## Requirements
- R1: When `valid` is high, `result` equals floor(256 × Σ(w_i × z_i) / Σ w_i), truncated and never rounded, where w_i is the strength of rule i and z_i is its output constant.
- R2: The strength of rule i sits in `strengths[8i+7:8i]`. Rule i pairs traffic term t = i / 3 (0 lightest, 4 heaviest) with change term c = i % 3 (0 slowest, 2 fastest).
- R3: The output constants are low = 0x20, normal = 0x80 and high = 0xE0. The rule-map codes are 0 = low, 1 = normal and 2 = high. The codes by traffic term, each listed for change terms 0,1,2, are:
  - t0: 0,0,0
  - t1: 0,0,1
  - t2: 1,1,2
  - t3: 1,2,2
  - t4: 2,2,2
- R4: When every strength is zero, the result is 256 × low = 0x2000, delivered with the usual `valid` timing.
- R5: A `start` sampled high on a rising edge makes `valid` high after the third rising edge, counting the sampling edge as the first. `valid` stays high for exactly one cycle.
- R6: `start` may be high on consecutive cycles. Each such cycle gives its own result, in order, on consecutive cycles.
- R7: While `rst_n` is low, `valid` and `result` are 0.
- R8: Strengths presented while `start` is low raise no `valid` and do not alter any later result.
- R9: Whenever `valid` is high, `result` lies between 256 × 0x20 and 256 × 0xE0.
- R10: With all fifteen strengths at 0xFF, the accumulation does not overflow, and the result is 0x8666.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a computation on the current strengths |
| strengths | input | 120 | Fifteen packed 8-bit rule firing strengths |
| valid | output | 1 | One-cycle marker that `result` is new |
| result | output | 16 | Weighted average scaled by 256 |

## Verification
On every cycle, the assertions check three things: the fixed three-edge latency, the result staying inside the range spanned by the output constants, and the zero-weight bypass. The bench scenarios are the only place that shows the exact quotient values. They show the truncation of a non-integer average, the rule map picking the right constant for each rule position, the full-scale case without overflow, and back-to-back launches keeping their order. They also show that strengths presented without `start` leave later results unchanged.

// File: rtl/wavg_defuzz.sv
module wavg_defuzz #(
  parameter int W_BITS    = 8,
  parameter int N_RULES   = 15,
  parameter int OUT_BITS  = 16,
  parameter int FRAC_BITS = 8,
  parameter logic [W_BITS-1:0] LVL_LO  = 8'h20,
  parameter logic [W_BITS-1:0] LVL_MID = 8'h80,
  parameter logic [W_BITS-1:0] LVL_HI  = 8'hE0,
  parameter logic [2*N_RULES-1:0] RULE_MAP = {
    2'd2, 2'd2, 2'd2,
    2'd2, 2'd2, 2'd1,
    2'd2, 2'd1, 2'd1,
    2'd1, 2'd0, 2'd0,
    2'd0, 2'd0, 2'd0}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [N_RULES*W_BITS-1:0]  strengths,
  output logic                       valid,
  output logic [OUT_BITS-1:0]        result
);

  localparam int CNT_W = $clog2(N_RULES + 1);
  localparam int NUM_W = 2 * W_BITS + CNT_W;
  localparam int DEN_W = W_BITS + CNT_W;
  localparam int QUO_W = NUM_W + FRAC_BITS;
  localparam logic [W_BITS-1:0] LVL_MAXA = (LVL_LO > LVL_MID) ? LVL_LO : LVL_MID;
  localparam logic [W_BITS-1:0] LVL_MAX  = (LVL_MAXA > LVL_HI) ? LVL_MAXA : LVL_HI;
  localparam logic [W_BITS-1:0] LVL_MINA = (LVL_LO < LVL_MID) ? LVL_LO : LVL_MID;
  localparam logic [W_BITS-1:0] LVL_MIN  = (LVL_MINA < LVL_HI) ? LVL_MINA : LVL_HI;
  localparam logic [OUT_BITS-1:0] LO_SCALED  = OUT_BITS'(LVL_LO)  << FRAC_BITS;
  localparam logic [OUT_BITS-1:0] MAX_SCALED = OUT_BITS'(LVL_MAX) << FRAC_BITS;
  localparam logic [OUT_BITS-1:0] MIN_SCALED = OUT_BITS'(LVL_MIN) << FRAC_BITS;

  logic [NUM_W-1:0]    num_c, num_q;
  logic [DEN_W-1:0]    den_c, den_q;
  logic [OUT_BITS-1:0] quo_q;
  logic                v1, v2;

  always_comb begin
    num_c = '0;
    den_c = '0;
    for (int i = 0; i < N_RULES; i++) begin
      logic [1:0]        code;
      logic [W_BITS-1:0] z;
      logic [W_BITS-1:0] w;
      code = RULE_MAP[2*i +: 2];
      w    = strengths[W_BITS*i +: W_BITS];
      z    = (code == 2'd0) ? LVL_LO : (code == 2'd1) ? LVL_MID : LVL_HI;
      num_c = num_c + NUM_W'(w) * NUM_W'(z);
      den_c = den_c + DEN_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      num_q <= '0;
      den_q <= '0;
    end else begin
      v1 <= start;
      if (start) begin
        num_q <= num_c;
        den_q <= den_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2    <= 1'b0;
      quo_q <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        if (den_q == '0)
          quo_q <= LO_SCALED;
        else
          quo_q <= OUT_BITS'({num_q, {FRAC_BITS{1'b0}}} / QUO_W'(den_q));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      result <= '0;
    end else begin
      valid <= v2;
      if (v2) result <= quo_q;
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##3 valid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(start, 3));

  assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && den_q == '0) |-> ##2 (valid && result == LO_SCALED));

  assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> result <= MAX_SCALED);

  assert_lower_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> result >= MIN_SCALED);

endmodule

// File: tb/sim_wavg_defuzz.sv
module sim_wavg_defuzz;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [119:0] strengths = '0;
  logic         valid;
  logic [15:0]  result;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  wavg_defuzz u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strengths(strengths), .valid(valid), .result(result)
  );

  localparam int NV = 9;
  localparam logic [119:0] STIM [NV] = '{
    120'd0,
    120'd255,
    120'd1 << 112,
    120'd100 | (120'd100 << 112),
    120'd255 << 48,
    120'd1 | (120'd2 << 112),
    120'd1 | (120'd2 << 40),
    120'd6 | (120'd1 << 112),
    {15{8'hFF}}
  };
  localparam logic [15:0] EXPV [NV] = '{
    16'h2000, 16'h2000, 16'hE000, 16'h8000, 16'h8000,
    16'hA000, 16'h6000, 16'h3B6D, 16'h8666
  };
  localparam string TAG [NV] = '{
    "R4 zero", "R3 low", "R3 high", "R1 mix", "R2 rule6",
    "R1 exact", "R2 rule5", "R1 trunc", "R10 full"
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [119:0] w, input logic [15:0] exp, input string req);
    @(negedge clk); start = 1'b1; strengths = w;
    @(negedge clk); start = 1'b0; strengths = '0;
    @(negedge clk); check({req, " R5 early"}, 16'(valid), 16'd0);
    @(negedge clk); check({req, " R5 valid"}, 16'(valid), 16'd1);
    check(req, result, exp);
    @(negedge clk); check({req, " R5 pulse"}, 16'(valid), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset valid", 16'(valid), 16'd0);
    check("R7 reset result", result, 16'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_one(STIM[k], EXPV[k], TAG[k]);

    // R6 back-to-back launches
    @(negedge clk); start = 1'b1; strengths = STIM[3];
    @(negedge clk); strengths = STIM[5];
    @(negedge clk); strengths = STIM[7];
    @(negedge clk); start = 1'b0; strengths = '0;
    check("R6 first valid", 16'(valid), 16'd1);
    check("R6 first", result, 16'h8000);
    @(negedge clk); check("R6 second", result, 16'hA000);
    check("R6 second valid", 16'(valid), 16'd1);
    @(negedge clk); check("R6 third", result, 16'h3B6D);
    check("R6 third valid", 16'(valid), 16'd1);
    @(negedge clk); check("R6 end", 16'(valid), 16'd0);

    // R8 strengths without start are ignored
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); strengths = {15{8'hFF}} ^ (120'(k) << 8);
      check("R8 no valid", 16'(valid), 16'd0);
    end
    check("R8 result held", result, 16'h3B6D);
    run_one(STIM[6], 16'h6000, "R8 after idle");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule